// File: doc/BRIEF.md
# TLB-Backed Paged Address Translator

This block turns a logical address into a physical address for one requester. The low `OFF_W` bits of the logical address are the offset within a page and pass through unchanged. The bits above them form the page number. That number is looked up in a small fully associative translation cache. Each cache entry is tagged with the page number and an address-space identifier, and it holds the frame number, the permission bits and a modified flag. On a hit the block returns the frame number joined to the offset.

On a miss the block fetches one page-table entry from a word-addressed memory port. That entry sits at the table base plus the page number. The block checks the entry, installs it in the slot chosen by a round-robin pointer, and then completes the access. If that slot holds a modified mapping, the block first writes the mapping back to the table. Software sets the table base and a table length through a configuration port. Writing the base also switches to a new table, so it empties the cache.

Top module: `xlateTop`

## Requirements
- R1: A request whose page number and identifier both match a cached entry, and whose access is permitted, raises `done` in the cycle after the request. It reports `fault` = 0 and `physAddr` = {frame, offset}, and it makes no memory request.
- R2: A page number greater than or equal to the table length register faults with code 1 in the cycle after the request, with no memory request. The length check comes before any cache lookup.
- R3: On a miss with a clean victim, exactly one memory read is issued, at address base + page number. `done` rises in the cycle after the one in which `memAck` is high. `physAddr` is taken from the fetched entry. A table entry is laid out as bit 12 modified, bit 11 valid, bits 10:8 permissions {read, write, execute}, and bits 7:0 frame.
- R4: A fetched entry with the valid bit clear faults with code 2 and is not cached, so repeating the access reads memory again.
- R5: Access codes are 0 = read, 1 = write and 2 = execute. An access whose permission bit is clear faults with code 3. This applies both on a hit and on a refill. A valid entry is cached even when the access that fetched it faults.
- R6: A hit requires the identifier stored with the entry to equal `reqAsid`. The same page under another identifier misses.
- R7: Writing the base register (`cfgSel` = 0) invalidates every cached entry and restarts replacement at slot 0. Writing the length register (`cfgSel` = 1) leaves the cache unchanged.
- R8: Refills fill slots in round-robin order. Once all `ENTRIES` slots are in use, the next refill replaces the oldest fill.
- R9: A permitted write, on a hit or on a refill, marks the cached entry modified. Evicting a modified entry first issues a memory write (`memWe` = 1) to base + its page, with data {modified=1, valid=1, permissions, frame}. Evicting a clean entry issues no write.
- R10: A completed access with a nonzero fault code returns `physAddr` = 0. A successful access returns fault code 0.
- R11: After reset `done` and `memReq` are low, and the table length is 0, so every access faults with code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request, accepted when the block is idle |
| reqAddr | input | 16 | Logical address |
| reqAcc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| reqAsid | input | 4 | Current address-space identifier |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the table base, 1 selects the table length |
| cfgData | input | 16 | Configuration write data |
| memReq | output | 1 | One-cycle memory request pulse |
| memWe | output | 1 | Request is a write-back |
| memAddr | output | 16 | Table word address |
| memWdata | output | 13 | Write-back entry |
| memAck | input | 1 | Memory response, one cycle |
| memRdata | input | 13 | Fetched table entry, valid with memAck |
| done | output | 1 | Access complete, one cycle |
| physAddr | output | 16 | Translated address |
| fault | output | 2 | 0 none, 1 length, 2 invalid, 3 protection |

## Verification
Hits, length faults and faulting hits are due exactly one cycle after the request edge. Every table access is due exactly one cycle after the cycle in which `memAck` is high. Each request is issued on a falling edge, and every later falling edge is counted as one elapsed cycle. The count at which `memAck` is seen is noted, and `done` is required at exactly that count plus one, or at count 1 when no memory traffic is expected. The bench's memory model responds a fixed number of cycles after each request pulse. It counts reads and writes separately, so each check also confirms how many table accesses took place.

// File: rtl/xlatePkg.sv
package xlatePkg;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] FLT_NONE    = 2'd0;
  localparam logic [1:0] FLT_LEN     = 2'd1;
  localparam logic [1:0] FLT_INVALID = 2'd2;
  localparam logic [1:0] FLT_PROT    = 2'd3;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;     // latch the live request
    logic finishLen;  // complete with a length fault
    logic finishHit;  // complete from the cache
    logic issueWb;    // memory write-back of the victim this cycle
    logic issueRd;    // memory read of the table entry this cycle
    logic takeRsp;    // table entry on memRdata, refill and complete
  } ctlStrobes_t;

  // permission field order is {read, write, execute}
  function automatic logic accessAllowed(input logic [2:0] rwx, input logic [1:0] acc);
    case (acc)
      ACC_READ:  return rwx[2];
      ACC_WRITE: return rwx[1];
      ACC_EXEC:  return rwx[0];
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xlateDatapath.sv
module xlateDatapath
  import xlatePkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int ASID_W  = 4,
  parameter int ENTRIES = 16,
  parameter int MADDR_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobes_t                 stb,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [1:0]                  reqAcc,
  input  logic [ASID_W-1:0]           reqAsid,
  input  logic                        cfgWe,
  input  logic                        cfgSel,
  input  logic [MADDR_W-1:0]          cfgData,
  input  logic [FRAME_W+4:0]          memRdata,
  output logic                        lookupHit,
  output logic                        lenBad,
  output logic                        victimDirty,
  output logic [MADDR_W-1:0]          memAddr,
  output logic [FRAME_W+4:0]          memWdata,
  output logic                        doneOut,
  output logic [FRAME_W+OFF_W-1:0]    physOut,
  output logic [1:0]                  faultOut
);

  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int PA_W   = FRAME_W + OFF_W;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // configuration registers
  logic [MADDR_W-1:0] ptBase, ptLen;
  logic flushNow;
  assign flushNow = cfgWe && !cfgSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptBase <= '0;
      ptLen  <= '0;
    end else if (cfgWe) begin
      if (cfgSel) ptLen  <= cfgData;
      else        ptBase <= cfgData;
    end
  end

  // live request fields
  logic [PAGE_W-1:0] livePage;
  logic [OFF_W-1:0]  liveOff;
  assign livePage = reqAddr[ADDR_W-1:OFF_W];
  assign liveOff  = reqAddr[OFF_W-1:0];
  assign lenBad   = (MADDR_W'(livePage) >= ptLen);

  // latched request for the refill path
  logic [PAGE_W-1:0] curPage;
  logic [OFF_W-1:0]  curOff;
  logic [1:0]        curAcc;
  logic [ASID_W-1:0] curAsid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPage <= '0;
      curOff  <= '0;
      curAcc  <= ACC_READ;
      curAsid <= '0;
    end else if (stb.accept) begin
      curPage <= livePage;
      curOff  <= liveOff;
      curAcc  <= reqAcc;
      curAsid <= reqAsid;
    end
  end

  // translation cache storage
  logic [ENTRIES-1:0] entValid, entDirty;
  logic [PAGE_W-1:0]  entPage  [ENTRIES];
  logic [ASID_W-1:0]  entAsid  [ENTRIES];
  logic [FRAME_W-1:0] entFrame [ENTRIES];
  logic [2:0]         entPerm  [ENTRIES];
  logic [IDX_W-1:0]   victimPtr;

  // associative match
  logic [ENTRIES-1:0] hitVec;
  logic [IDX_W-1:0]   hitIdx;

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign hitVec[g] = entValid[g] && (entPage[g] == livePage) && (entAsid[g] == reqAsid);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign lookupHit = |hitVec;

  logic hitAllowed;
  assign hitAllowed = accessAllowed(entPerm[hitIdx], reqAcc);

  // fetched table entry fields
  logic [FRAME_W-1:0] pteFrame;
  logic [2:0]         ptePerm;
  logic               pteValid, pteDirty, pteAllowed;
  assign pteFrame   = memRdata[FRAME_W-1:0];
  assign ptePerm    = memRdata[FRAME_W+2:FRAME_W];
  assign pteValid   = memRdata[FRAME_W+3];
  assign pteDirty   = memRdata[FRAME_W+4];
  assign pteAllowed = accessAllowed(ptePerm, curAcc);

  // victim selection and write-back image
  logic [IDX_W-1:0] victimNext;
  assign victimNext  = (victimPtr == IDX_W'(ENTRIES - 1)) ? '0 : victimPtr + 1'b1;
  assign victimDirty = entValid[victimPtr] && entDirty[victimPtr];
  assign memWdata    = {1'b1, 1'b1, entPerm[victimPtr], entFrame[victimPtr]};
  assign memAddr     = ptBase + MADDR_W'(stb.issueWb ? entPage[victimPtr] : curPage);

  // entry state bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid  <= '0;
      entDirty  <= '0;
      victimPtr <= '0;
    end else if (flushNow) begin
      entValid  <= '0;
      entDirty  <= '0;
      victimPtr <= '0;
    end else begin
      if (stb.finishHit && lookupHit && hitAllowed && reqAcc == ACC_WRITE)
        entDirty[hitIdx] <= 1'b1;
      if (stb.takeRsp && pteValid) begin
        entValid[victimPtr] <= 1'b1;
        entDirty[victimPtr] <= pteDirty || (curAcc == ACC_WRITE && pteAllowed);
        victimPtr           <= victimNext;
      end
    end
  end

  // entry payload
  always_ff @(posedge clk) begin
    if (stb.takeRsp && pteValid) begin
      entPage[victimPtr]  <= curPage;
      entAsid[victimPtr]  <= curAsid;
      entFrame[victimPtr] <= pteFrame;
      entPerm[victimPtr]  <= ptePerm;
    end
  end

  // completion registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneOut  <= 1'b0;
      physOut  <= '0;
      faultOut <= FLT_NONE;
    end else begin
      doneOut <= 1'b0;
      if (stb.finishLen) begin
        doneOut  <= 1'b1;
        faultOut <= FLT_LEN;
        physOut  <= '0;
      end else if (stb.finishHit) begin
        doneOut <= 1'b1;
        if (hitAllowed) begin
          faultOut <= FLT_NONE;
          physOut  <= PA_W'({entFrame[hitIdx], liveOff});
        end else begin
          faultOut <= FLT_PROT;
          physOut  <= '0;
        end
      end else if (stb.takeRsp) begin
        doneOut <= 1'b1;
        if (!pteValid) begin
          faultOut <= FLT_INVALID;
          physOut  <= '0;
        end else if (!pteAllowed) begin
          faultOut <= FLT_PROT;
          physOut  <= '0;
        end else begin
          faultOut <= FLT_NONE;
          physOut  <= PA_W'({pteFrame, curOff});
        end
      end
    end
  end

  // R6: no page/identifier pair is ever cached twice
  a_r6_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R7: a base write leaves no valid entry behind
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    (flushNow && !stb.takeRsp) |=> (entValid == '0));

  // R10: a faulting completion carries no address
  a_r10_fault_no_addr: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && faultOut != FLT_NONE) |-> (physOut == '0));

endmodule

// File: rtl/xlateControl.sv
module xlateControl
  import xlatePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lookupHit,
  input  logic        lenBad,
  input  logic        victimDirty,
  input  logic        memAck,
  output ctlStrobes_t stb,
  output logic        memReq,
  output logic        memWe
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB_REQ,
    ST_WB_WAIT,
    ST_RD_REQ,
    ST_RD_WAIT
  } ctlState_t;

  ctlState_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.accept = 1'b1;
          if (lenBad)         stb.finishLen = 1'b1;
          else if (lookupHit) stb.finishHit = 1'b1;
          else                stateNext = victimDirty ? ST_WB_REQ : ST_RD_REQ;
        end
      end
      ST_WB_REQ: begin
        stb.issueWb = 1'b1;
        stateNext   = ST_WB_WAIT;
      end
      ST_WB_WAIT: if (memAck) stateNext = ST_RD_REQ;
      ST_RD_REQ: begin
        stb.issueRd = 1'b1;
        stateNext   = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (memAck) begin
          stb.takeRsp = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReq = stb.issueWb || stb.issueRd;
  assign memWe  = stb.issueWb;

  // R2: a length fault never reaches the memory port
  a_r2_len_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && lenBad) |=> !memReq);

  // R3: each memory request is a single-cycle pulse
  a_r3_mem_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R9: a write-back is always followed by the entry read
  a_r9_wb_then_read: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WB_WAIT && memAck) |=> (memReq && !memWe));

endmodule

// File: rtl/xlateTop.sv
module xlateTop
  import xlatePkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int ASID_W  = 4,
  parameter int ENTRIES = 16,
  parameter int MADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [1:0]               reqAcc,
  input  logic [ASID_W-1:0]        reqAsid,
  input  logic                     cfgWe,
  input  logic                     cfgSel,
  input  logic [MADDR_W-1:0]       cfgData,
  output logic                     memReq,
  output logic                     memWe,
  output logic [MADDR_W-1:0]       memAddr,
  output logic [FRAME_W+4:0]       memWdata,
  input  logic                     memAck,
  input  logic [FRAME_W+4:0]       memRdata,
  output logic                     done,
  output logic [FRAME_W+OFF_W-1:0] physAddr,
  output logic [1:0]               fault
);

  ctlStrobes_t stb;
  logic lookupHit, lenBad, victimDirty;

  xlateControl uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .lookupHit   (lookupHit),
    .lenBad      (lenBad),
    .victimDirty (victimDirty),
    .memAck      (memAck),
    .stb         (stb),
    .memReq      (memReq),
    .memWe       (memWe)
  );

  xlateDatapath #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .FRAME_W (FRAME_W),
    .ASID_W  (ASID_W),
    .ENTRIES (ENTRIES),
    .MADDR_W (MADDR_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reqAddr     (reqAddr),
    .reqAcc      (reqAcc),
    .reqAsid     (reqAsid),
    .cfgWe       (cfgWe),
    .cfgSel      (cfgSel),
    .cfgData     (cfgData),
    .memRdata    (memRdata),
    .lookupHit   (lookupHit),
    .lenBad      (lenBad),
    .victimDirty (victimDirty),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .doneOut     (done),
    .physOut     (physAddr),
    .faultOut    (fault)
  );

  // R1: a cache completion shows up on the next cycle
  a_r1_hit_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    stb.finishHit |=> done);

  // R3: a table response completes the access on the next cycle
  a_r3_rsp_done: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeRsp |=> done);

endmodule

// File: tb/tb_xlateTop.sv
module tb_xlateTop;
  import xlatePkg::*;

  localparam int PTE_W = 13;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqAcc = ACC_READ;
  logic [3:0]  reqAsid = '0;
  logic cfgWe = 1'b0, cfgSel = 1'b0;
  logic [15:0] cfgData = '0;
  logic memReq, memWe;
  logic [15:0] memAddr;
  logic [PTE_W-1:0] memWdata;
  logic memAck = 1'b0;
  logic [PTE_W-1:0] memRdata = '0;
  logic done;
  logic [15:0] physAddr;
  logic [1:0] fault;

  xlateTop dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqAcc(reqAcc),
    .reqAsid(reqAsid), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .done(done), .physAddr(physAddr), .fault(fault)
  );

  logic [PTE_W-1:0] mem [0:1023];
  int checks = 0, fails = 0, rdCount = 0, wrCount = 0, pendCnt = 0;
  logic [9:0]  pendAddr = '0;
  logic [15:0] lastWrAddr = '0;
  logic [PTE_W-1:0] lastWrData = '0;

  // table memory: fixed response latency
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        memAck   <= 1'b1;
        memRdata <= mem[pendAddr];
      end
    end
    if (memReq) begin
      pendAddr = memAddr[9:0];
      pendCnt  = LAT;
      if (memWe) begin
        wrCount++;
        lastWrAddr = memAddr;
        lastWrData = memWdata;
        mem[memAddr[9:0]] = memWdata;
      end else begin
        rdCount++;
      end
    end
  end

  function automatic logic [15:0] paA(input logic [7:0] page, input logic [7:0] off);
    return {page ^ 8'hA5, off};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [15:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // viaMem: 1 = exactly one table read expected, 0 = none
  task automatic expectXlate(input string tag, input logic [15:0] a, input logic [1:0] acc,
                             input logic [3:0] asid, input bit viaMem,
                             input logic [1:0] expF, input logic [15:0] expPa);
    int lat, ackAt, rd0;
    rd0 = rdCount; ackAt = -1; lat = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqAcc = acc; reqAsid = asid;
    do begin
      @(negedge clk);
      reqValid = 1'b0;
      lat++;
      if (memAck) ackAt = lat;
    end while (!done && lat < 300);
    check({tag, " fault"}, 32'(fault), 32'(expF));
    check({tag, " physAddr"}, 32'(physAddr), 32'(expPa));
    if (viaMem) begin
      check({tag, " reads"}, 32'(rdCount - rd0), 32'd1);
      check({tag, " latency after ack"}, 32'(lat), 32'(ackAt + 1));
    end else begin
      check({tag, " reads"}, 32'(rdCount - rd0), 32'd0);
      check({tag, " latency"}, 32'(lat), 32'd1);
    end
  endtask

  task automatic testReset;
    check("R11 done after reset", 32'(done), 32'd0);
    check("R11 memReq after reset", 32'(memReq), 32'd0);
    expectXlate("R11 R2 zero length", 16'h0312, ACC_READ, 4'd1, 1'b0, FLT_LEN, 16'h0);
  endtask

  task automatic testMissHit;
    expectXlate("R3 R10 miss read", 16'h0512, ACC_READ, 4'd1, 1'b1, FLT_NONE, paA(8'h05, 8'h12));
    expectXlate("R1 hit read", 16'h05C3, ACC_READ, 4'd1, 1'b0, FLT_NONE, paA(8'h05, 8'hC3));
    expectXlate("R1 hit exec", 16'h0500, ACC_EXEC, 4'd1, 1'b0, FLT_NONE, paA(8'h05, 8'h00));
  endtask

  task automatic testLength;
    expectXlate("R2 page at length", 16'h4001, ACC_READ, 4'd1, 1'b0, FLT_LEN, 16'h0);
    expectXlate("R2 last page inside", 16'h3F7E, ACC_READ, 4'd1, 1'b1, FLT_NONE, paA(8'h3F, 8'h7E));
  endtask

  task automatic testInvalid;
    expectXlate("R4 invalid first", 16'h0710, ACC_READ, 4'd1, 1'b1, FLT_INVALID, 16'h0);
    expectXlate("R4 invalid not cached", 16'h0710, ACC_READ, 4'd1, 1'b1, FLT_INVALID, 16'h0);
  endtask

  task automatic testProtect;
    expectXlate("R5 write to read-only refill", 16'h0920, ACC_WRITE, 4'd1, 1'b1, FLT_PROT, 16'h0);
    expectXlate("R5 read-only cached read", 16'h0921, ACC_READ, 4'd1, 1'b0, FLT_NONE, paA(8'h09, 8'h21));
    expectXlate("R5 write to read-only hit", 16'h0922, ACC_WRITE, 4'd1, 1'b0, FLT_PROT, 16'h0);
    expectXlate("R5 read of exec-only", 16'h0C00, ACC_READ, 4'd1, 1'b1, FLT_PROT, 16'h0);
    expectXlate("R5 exec of exec-only", 16'h0C44, ACC_EXEC, 4'd1, 1'b0, FLT_NONE, paA(8'h0C, 8'h44));
    expectXlate("R5 exec of read-write", 16'h0B01, ACC_EXEC, 4'd1, 1'b1, FLT_PROT, 16'h0);
  endtask

  task automatic testAsid;
    expectXlate("R6 other identifier misses", 16'h0533, ACC_READ, 4'd2, 1'b1, FLT_NONE, paA(8'h05, 8'h33));
    expectXlate("R6 own identifier hits", 16'h0534, ACC_READ, 4'd1, 1'b0, FLT_NONE, paA(8'h05, 8'h34));
  endtask

  task automatic testFlush;
    cfgWrite(1'b1, 16'h0030);
    expectXlate("R7 length write keeps cache", 16'h0501, ACC_READ, 4'd1, 1'b0, FLT_NONE, paA(8'h05, 8'h01));
    cfgWrite(1'b0, 16'h0200);
    expectXlate("R7 base write flushes", 16'h0502, ACC_READ, 4'd1, 1'b1, FLT_NONE, 16'h3502);
  endtask

  task automatic testReplace;
    int wr0;
    cfgWrite(1'b0, 16'h0100);
    cfgWrite(1'b1, 16'h0040);
    wr0 = wrCount;
    expectXlate("R9 write refill", 16'h0A10, ACC_WRITE, 4'd1, 1'b1, FLT_NONE, paA(8'h0A, 8'h10));
    expectXlate("R8 fill slot 1", 16'h2000, ACC_READ, 4'd1, 1'b1, FLT_NONE, paA(8'h20, 8'h00));
    expectXlate("R9 write hit", 16'h2001, ACC_WRITE, 4'd1, 1'b0, FLT_NONE, paA(8'h20, 8'h01));
    for (int p = 8'h21; p <= 8'h2E; p++)
      expectXlate("R8 fill", {8'(p), 8'h05}, ACC_READ, 4'd1, 1'b1, FLT_NONE, paA(8'(p), 8'h05));
    expectXlate("R8 all slots still held", 16'h2106, ACC_READ, 4'd1, 1'b0, FLT_NONE, paA(8'h21, 8'h06));
    check("R9 no write-back before eviction", 32'(wrCount - wr0), 32'd0);
    expectXlate("R8 R9 evict oldest", 16'h2F00, ACC_READ, 4'd1, 1'b1, FLT_NONE, paA(8'h2F, 8'h00));
    check("R9 write-back count refill-dirty", 32'(wrCount - wr0), 32'd1);
    check("R9 write-back address", 32'(lastWrAddr), 32'h010A);
    check("R9 write-back data", 32'(lastWrData), 32'({2'b11, 3'b111, 8'h0A ^ 8'hA5}));
    expectXlate("R9 evict hit-dirty", 16'h3000, ACC_READ, 4'd1, 1'b1, FLT_NONE, paA(8'h30, 8'h00));
    check("R9 write-back count hit-dirty", 32'(wrCount - wr0), 32'd2);
    check("R9 hit-dirty address", 32'(lastWrAddr), 32'h0120);
    check("R9 hit-dirty data", 32'(lastWrData), 32'({2'b11, 3'b111, 8'h20 ^ 8'hA5}));
    expectXlate("R8 evicted page misses", 16'h0A11, ACC_READ, 4'd1, 1'b1, FLT_NONE, paA(8'h0A, 8'h11));
    check("R9 clean eviction no write", 32'(wrCount - wr0), 32'd2);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    for (int p = 0; p < 256; p++) begin
      mem[256 + p] = {1'b0, 1'b1, 3'b111, 8'(p) ^ 8'hA5};
      mem[512 + p] = {1'b0, 1'b1, 3'b111, 8'(p) + 8'h30};
    end
    for (int p = 0; p < 256; p++) mem[p] = '0;
    for (int p = 768; p < 1024; p++) mem[p] = '0;
    mem[256 + 7]  = {1'b0, 1'b0, 3'b111, 8'h07 ^ 8'hA5};
    mem[256 + 9]  = {1'b0, 1'b1, 3'b100, 8'h09 ^ 8'hA5};
    mem[256 + 11] = {1'b0, 1'b1, 3'b110, 8'h0B ^ 8'hA5};
    mem[256 + 12] = {1'b0, 1'b1, 3'b001, 8'h0C ^ 8'hA5};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    cfgWrite(1'b0, 16'h0100);
    cfgWrite(1'b1, 16'h0040);
    testMissHit();
    testLength();
    testInvalid();
    testProtect();
    testAsid();
    testFlush();
    testReplace();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule